// File: doc/BRIEF.md
# Half-Bridge Overcurrent Shutdown Latch

This block protects several half-bridge outputs against overcurrent. Each channel has a comparator flag that is high while the high-side or low-side current is above its threshold. The block holds the on/off request and the side selection for each channel. These come from the decoded fields of the serial command, which arrive with a one-cycle completion strobe. From them it drives a high-side enable and a low-side enable per channel, a 2-bit status code per channel, and one global overcurrent flag. That flag feeds bit 15 of the serial status word.

Each channel runs its own four-state machine:
- `CH_OFF`: the channel is not requested. Both drivers are off.
- `CH_DRIVE`: the channel is requested and no overcurrent is present. One driver is on.
- `CH_QUALIFY`: an overcurrent is present and being timed. The driver stays on.
- `CH_TRIPPED`: the shutdown is latched. Both drivers are off.

Transitions:
- `go_drive`: `CH_OFF` to `CH_DRIVE` when the channel is requested.
- `go_off`: `CH_DRIVE` or `CH_QUALIFY` to `CH_OFF` when the request is removed.
- `arm`: `CH_DRIVE` to `CH_QUALIFY` on a flag seen while driving.
- `disarm`: `CH_QUALIFY` to `CH_DRIVE` when the flag drops early.
- `trip`: `CH_QUALIFY` to `CH_TRIPPED` when the count expires. With a delay of 1 this goes straight from `CH_DRIVE`.
- `release`: `CH_TRIPPED` to `CH_DRIVE` or `CH_OFF` on a command whose status-reset bit is 1. The target is chosen by that command's on bit.

Top module: `ocp_latch_ctrl`

## Requirements
- R1: One cycle after a strobe, each requested channel drives exactly one enable: the high side when its side bit is 1, the low side when it is 0. Its status is 11. An unrequested channel has both enables low and status 00.
- R2: A driving channel latches off at the clock edge that samples its overcurrent flag high for the TRIP_DELAY-th consecutive time.
- R3: If the flag drops before the count expires, the count restarts from zero.
- R4: A latched channel has both its high-side and low-side enables low.
- R5: A latched channel reports status 01.
- R6: `oc_global` is 1 exactly when at least one channel is latched.
- R7: Commands whose status-reset bit is 0 leave a latched channel latched. Their on/side fields are still recorded.
- R8: A command with the status-reset bit at 1 clears every latch. Each cleared channel takes the on/side state of that same command.
- R9: If the flag is still high when the latch is cleared, qualification restarts from zero. The channel latches again only after a further full TRIP_DELAY cycles.
- R10: A channel that is commanded off never arms, whatever its flag does. Its status stays 00.
- R11: No channel ever has both enables high at once.
- R12: After reset all enables are low, all status codes are 00 and `oc_global` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | N_CH | Per-channel overcurrent comparator flag |
| cmd_strobe | input | 1 | One-cycle pulse per completed serial command |
| cmd_on | input | N_CH | Decoded per-channel on request |
| cmd_hi | input | N_CH | Decoded side select: 1 high side, 0 low side |
| cmd_srr | input | 1 | Decoded status-reset bit |
| hs_en | output | N_CH | High-side driver enables |
| ls_en | output | N_CH | Low-side driver enables |
| ch_status | output | 2*N_CH | Per-channel status: 00 off, 11 driving, 01 overcurrent latched |
| oc_global | output | 1 | OR of all latched overcurrent faults |

## Verification
Two events can land on the same clock edge. One channel's qualification count can expire on exactly the edge that samples a status-reset command. The bench provokes this by raising one channel's flag and placing a strobe with the reset bit set on the TRIP_DELAY-th edge. The expected result is that the channel still latches, because the reset clears only latches that already exist. The behavioural model checks this on every clock, and a directed check confirms status 01 and a raised `oc_global` on the next cycle.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        CH_OFF      = 2'd0,
        CH_DRIVE    = 2'd1,
        CH_QUALIFY  = 2'd2,
        CH_TRIPPED  = 2'd3
    } ch_state_e;

    localparam logic [1:0] STAT_OFF = 2'b00;
    localparam logic [1:0] STAT_OC  = 2'b01;
    localparam logic [1:0] STAT_ON  = 2'b11;

endpackage

// File: rtl/ocp_cmd_hold.sv
module ocp_cmd_hold #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_strobe,
    input  logic [N_CH-1:0] cmd_on,
    input  logic [N_CH-1:0] cmd_hi,
    input  logic            cmd_srr,
    output logic [N_CH-1:0] req_on_q,
    output logic [N_CH-1:0] req_hi_q,
    output logic [N_CH-1:0] eff_on,
    output logic            clr_pulse
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_on_q <= '0;
            req_hi_q <= '0;
        end else if (cmd_strobe) begin
            req_on_q <= cmd_on;
            req_hi_q <= cmd_hi;
        end
    end

    // request as it will stand after this edge
    always_comb begin
        eff_on    = cmd_strobe ? cmd_on : req_on_q;
        clr_pulse = cmd_strobe & cmd_srr;
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |=> $stable(req_on_q) && $stable(req_hi_q));

endmodule

// File: rtl/ocp_chan_fsm.sv
module ocp_chan_fsm
    import ocp_pkg::*;
#(
    parameter int TRIP_DELAY = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc,
    input  logic       eff_on,
    input  logic       clr,
    input  logic       side_hi,
    output logic       hs,
    output logic       ls,
    output logic [1:0] status,
    output logic       tripped
);

    localparam int CW = $clog2(TRIP_DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(TRIP_DELAY - 1);

    ch_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            CH_OFF: begin
                if (eff_on) state_d = CH_DRIVE;               // go_drive
            end
            CH_DRIVE: begin
                if (!eff_on) begin
                    state_d = CH_OFF;                         // go_off
                end else if (oc) begin
                    if (LAST == '0) begin
                        state_d = CH_TRIPPED;                 // trip
                    end else begin
                        state_d = CH_QUALIFY;                 // arm
                        cnt_d   = CW'(1);
                    end
                end
            end
            CH_QUALIFY: begin
                if (!eff_on) begin
                    state_d = CH_OFF;                         // go_off
                end else if (!oc) begin
                    state_d = CH_DRIVE;                       // disarm
                end else if (cnt_q == LAST) begin
                    state_d = CH_TRIPPED;                     // trip
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            CH_TRIPPED: begin
                if (clr) state_d = eff_on ? CH_DRIVE : CH_OFF; // release
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        hs      = 1'b0;
        ls      = 1'b0;
        status  = STAT_OFF;
        tripped = 1'b0;
        unique case (state_q)
            CH_OFF: ;
            CH_DRIVE, CH_QUALIFY: begin
                hs     = side_hi;
                ls     = !side_hi;
                status = STAT_ON;
            end
            CH_TRIPPED: begin
                status  = STAT_OC;
                tripped = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    full_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tripped) |-> $past(oc) && ($past(cnt_q) == LAST));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_QUALIFY && !oc) |=> cnt_q == '0);

    // R4
    both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |-> !hs && !ls);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && !clr) |=> tripped);

    // R10
    off_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) |=> (state_q != CH_QUALIFY) && !tripped);

endmodule

// File: rtl/ocp_status_pack.sv
module ocp_status_pack #(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0]   trip_vec,
    input  logic [1:0]        stat_arr [N_CH],
    output logic [2*N_CH-1:0] ch_status,
    output logic              oc_global
);

    for (genvar g = 0; g < N_CH; g++) begin : g_pack
        assign ch_status[2*g +: 2] = stat_arr[g];
    end

    assign oc_global = |trip_vec;

endmodule

// File: rtl/ocp_latch_ctrl.sv
module ocp_latch_ctrl
    import ocp_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int TRIP_DELAY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   oc_flag,
    input  logic              cmd_strobe,
    input  logic [N_CH-1:0]   cmd_on,
    input  logic [N_CH-1:0]   cmd_hi,
    input  logic              cmd_srr,
    output logic [N_CH-1:0]   hs_en,
    output logic [N_CH-1:0]   ls_en,
    output logic [2*N_CH-1:0] ch_status,
    output logic              oc_global
);

    logic [N_CH-1:0] req_on_q, req_hi_q, eff_on, trip_vec;
    logic            clr_pulse;
    logic [1:0]      stat_arr [N_CH];

    ocp_cmd_hold #(.N_CH(N_CH)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_strobe (cmd_strobe),
        .cmd_on     (cmd_on),
        .cmd_hi     (cmd_hi),
        .cmd_srr    (cmd_srr),
        .req_on_q   (req_on_q),
        .req_hi_q   (req_hi_q),
        .eff_on     (eff_on),
        .clr_pulse  (clr_pulse)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        ocp_chan_fsm #(.TRIP_DELAY(TRIP_DELAY)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .oc      (oc_flag[g]),
            .eff_on  (eff_on[g]),
            .clr     (clr_pulse),
            .side_hi (req_hi_q[g]),
            .hs      (hs_en[g]),
            .ls      (ls_en[g]),
            .status  (stat_arr[g]),
            .tripped (trip_vec[g])
        );
    end

    ocp_status_pack #(.N_CH(N_CH)) u_pack (
        .trip_vec  (trip_vec),
        .stat_arr  (stat_arr),
        .ch_status (ch_status),
        .oc_global (oc_global)
    );

    // R11
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en & ls_en) == '0);

    // R1
    off_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && !cmd_srr && cmd_on == '0) |=> ((hs_en | ls_en) == '0));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_srr) |=> !$past(oc_global) || ($countones(trip_vec) <= $countones($past(trip_vec))));

endmodule

// File: tb/tb_ocp_latch_ctrl.sv
module tb_ocp_latch_ctrl;

    localparam int N  = 4;
    localparam int D  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   oc_flag = '0;
    logic           cmd_strobe = 1'b0;
    logic [N-1:0]   cmd_on = '0;
    logic [N-1:0]   cmd_hi = '0;
    logic           cmd_srr = 1'b0;
    logic [N-1:0]   hs_en, ls_en;
    logic [2*N-1:0] ch_status;
    logic           oc_global;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference
    bit m_on [N];
    bit m_hi [N];
    bit m_trip [N];
    int m_cnt [N];

    always #2 clk = ~clk;

    ocp_latch_ctrl #(.N_CH(N), .TRIP_DELAY(D)) dut (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .cmd_strobe(cmd_strobe),
        .cmd_on(cmd_on), .cmd_hi(cmd_hi), .cmd_srr(cmd_srr),
        .hs_en(hs_en), .ls_en(ls_en), .ch_status(ch_status), .oc_global(oc_global)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_on[i] = 0; m_hi[i] = 0; m_trip[i] = 0; m_cnt[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                bit was_drv, now_on;
                was_drv = m_on[i] && !m_trip[i];
                now_on  = cmd_strobe ? cmd_on[i] : m_on[i];
                if (m_trip[i]) begin
                    if (cmd_strobe && cmd_srr) m_trip[i] = 0;
                    m_cnt[i] = 0;
                end else if (!now_on || !was_drv || !oc_flag[i]) begin
                    m_cnt[i] = 0;
                end else begin
                    m_cnt[i]++;
                    if (m_cnt[i] == D) begin
                        m_trip[i] = 1;
                        m_cnt[i] = 0;
                    end
                end
                if (cmd_strobe) begin
                    m_on[i] = cmd_on[i];
                    m_hi[i] = cmd_hi[i];
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit any_trip;
            any_trip = 0;
            for (int i = 0; i < N; i++) begin
                bit drv;
                int st;
                drv = m_on[i] && !m_trip[i];
                st  = m_trip[i] ? 1 : (drv ? 3 : 0);
                any_trip |= m_trip[i];
                chk(hs_en[i] == (drv && m_hi[i]), m_trip[i] ? "R4 hs" : "R1 hs",
                    int'(hs_en[i]), int'(drv && m_hi[i]));
                chk(ls_en[i] == (drv && !m_hi[i]), m_trip[i] ? "R4 ls" : "R1 ls",
                    int'(ls_en[i]), int'(drv && !m_hi[i]));
                chk(int'(ch_status[2*i +: 2]) == st, m_trip[i] ? "R5 status" : "R1 status",
                    int'(ch_status[2*i +: 2]), st);
                chk(!(hs_en[i] && ls_en[i]), "R11 both enables", int'(hs_en[i] & ls_en[i]), 0);
            end
            chk(oc_global == any_trip, "R6 global", int'(oc_global), int'(any_trip));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    task automatic send(input logic [N-1:0] on, input logic [N-1:0] hi, input logic srr);
        cmd_on = on; cmd_hi = hi; cmd_srr = srr; cmd_strobe = 1'b1;
        @(negedge clk);
        cmd_strobe = 1'b0; cmd_srr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hs_en == '0 && ls_en == '0, "R12 enables", int'(hs_en | ls_en), 0);
        chk(ch_status == '0 && !oc_global, "R12 status", int'(ch_status), 0);

        // R1: side selection
        send(4'b1111, 4'b0101, 1'b0);
        chk(hs_en == 4'b0101 && ls_en == 4'b1010, "R1 sides", int'({hs_en, ls_en}), 'h5a);
        chk(ch_status == 8'hff, "R1 status on", int'(ch_status), 'hff);

        // R3: interrupted overcurrent restarts
        oc_flag[0] = 1'b1;
        repeat (D-1) @(negedge clk);
        oc_flag[0] = 1'b0;
        @(negedge clk);
        oc_flag[0] = 1'b1;
        repeat (D-1) @(negedge clk);
        chk(ch_status[1:0] == 2'b11, "R3 not tripped after restart", int'(ch_status[1:0]), 3);
        // R2: D-th consecutive sample latches
        @(negedge clk);
        chk(ch_status[1:0] == 2'b01, "R2 tripped at delay", int'(ch_status[1:0]), 1);
        chk(!hs_en[0] && !ls_en[0], "R4 drivers off", int'({hs_en[0], ls_en[0]}), 0);
        chk(oc_global, "R6 global set", int'(oc_global), 1);

        // R7: reset bit 0 keeps latch
        send(4'b1011, 4'b0101, 1'b0);
        repeat (2) @(negedge clk);
        chk(ch_status[1:0] == 2'b01 && oc_global, "R7 still latched", int'(ch_status[1:0]), 1);

        // R10: channel 2 off ignores flag
        oc_flag[2] = 1'b1;
        repeat (2*D) @(negedge clk);
        chk(ch_status[5:4] == 2'b00 && !hs_en[2] && !ls_en[2], "R10 off ignores", int'(ch_status[5:4]), 0);
        oc_flag[2] = 1'b0;

        // R9: clear with flag still high restarts qualification
        send(4'b1111, 4'b0101, 1'b1);
        chk(ch_status[1:0] == 2'b11 && hs_en[0], "R8 cleared with flag", int'(ch_status[1:0]), 3);
        repeat (D-1) @(negedge clk);
        chk(ch_status[1:0] == 2'b11, "R9 not yet re-tripped", int'(ch_status[1:0]), 3);
        @(negedge clk);
        chk(ch_status[1:0] == 2'b01, "R9 re-tripped", int'(ch_status[1:0]), 1);

        // R8: clear after fault removed, on/side from same command
        oc_flag[0] = 1'b0;
        @(negedge clk);
        send(4'b1111, 4'b1100, 1'b1);
        chk(ch_status[1:0] == 2'b11 && ls_en[0] && !oc_global, "R8 restored", int'(ch_status[1:0]), 3);
        chk(hs_en == 4'b1100 && ls_en == 4'b0011, "R8 new sides", int'({hs_en, ls_en}), 'hc3);

        // same-cycle: expiry on channel 1 meets a reset command
        oc_flag[1] = 1'b1;
        repeat (D-1) @(negedge clk);
        send(4'b1111, 4'b1100, 1'b1);
        chk(ch_status[3:2] == 2'b01 && oc_global, "R2 trip beats concurrent reset", int'(ch_status[3:2]), 1);
        oc_flag[1] = 1'b0;
        send(4'b0000, 4'b0000, 1'b1);
        chk(ch_status == '0 && !oc_global, "R8 clear to off", int'(ch_status), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule